// File: doc/BRIEF.md
# PCI Power Management and Wake Signalling Controller

This block holds the power-state and wake context that a PCI network function presents to software. It also drives the function's active-low wake request line. Software reaches one 16-bit control/status register through a plain write strobe with two byte enables. The current contents can always be read back on a combinational read port. Three single-cycle event inputs report that the link state changed, that a magic packet matched, or that a wake-up frame matched. While the enable bit is set, any of these latches the status bit. The wake line is held low for as long as both status and enable are 1.

The block has three reset inputs. A power-on reset initialises everything. While it is low, the block also samples the auxiliary-power detect input, and it keeps that sample until the next power-on reset. When auxiliary power was seen, the block reports that it can signal wake from D3cold, and the wake context (enable and status) survives a hard reset. A hard reset returns the power state to D0 and, without auxiliary power, also clears the wake context. A soft reset leaves every software-visible bit and the wake line untouched. It only discards an event that is in flight. The register interface is control-only: there is no valid/ready flow and no back-pressure, so a write strobe always takes effect on the next clock edge.

Top module: `pm_wake_ctrl`

## Requirements
- R1: While por_n is low, the power state becomes D0, enable and status become 0, and pme_n becomes 1. After release, the read port shows 0 in every bit except the capability bit.
- R2: Register bits [1:0] hold the power state, encoded 00=D0, 01=D1, 11=D3hot. A write with reg_be[0]=1 loads this field, except that the value 10 (D2) leaves the current state unchanged.
- R3: Byte enables act independently and in any combination. With reg_be[0]=0, bits [7:0] are not changed; with reg_be[1]=0, bits [15:8] are not changed.
- R4: The register layout is: [1:0] power state, bit 8 wake enable (read/write), bit 12 D3cold wake capability (read-only), bit 15 wake status. Every other bit reads 0, and writes to those bits, and to bit 12, are ignored.
- R5: The status bit is write-one-to-clear through reg_be[1]. Writing 0 to bit 15 leaves it unchanged.
- R6: A pulse on evt_link, evt_magic or evt_frame while the enable bit is 1 sets the status bit, which is visible on the read port two clock edges after the pulse. A pulse while the enable bit is 0 is ignored.
- R7: pme_n goes low one clock edge after enable and status are both 1. It stays low until software clears status or enable, and it returns high one edge after that.
- R8: aux_pwr_det is sampled while por_n is low and held after release. The capability bit shows the held value, and later changes on aux_pwr_det have no effect.
- R9: A hard reset returns the power state to D0 and ignores writes. It clears enable and status only when auxiliary power was not latched. Otherwise it keeps them, and pme_n keeps following them.
- R10: A soft reset changes neither the read port nor pme_n.
- R11: When an event sets status in the same cycle as a write-one-to-clear of status, the status bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| hard_rst_n | input | 1 | Hard (bus) reset, active low, synchronous |
| soft_rst_n | input | 1 | Soft reset, active low, synchronous |
| aux_pwr_det | input | 1 | Auxiliary power present, sampled during power-on reset |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 2 | Byte enables for reg_wdata |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| evt_link | input | 1 | Link status change pulse |
| evt_magic | input | 1 | Magic packet match pulse |
| evt_frame | input | 1 | Wake-up frame match pulse |
| pme_n | output | 1 | Wake request, active low, registered |

## Verification
The bench builds the block with its defaults: three event sources and the 16-bit register. This lets every event input reach the status bit, and every byte-enable combination reach the fields that depend on it. It applies two power-on resets, one with auxiliary power present and one without. That brings both branches of the hard-reset rule within reach, along with the capability bit in both values. Collision timing is reached by placing a status clear in the exact cycle in which a staged event lands.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
  localparam int REG_W   = 16;
  localparam int BE_W    = REG_W / 8;
  localparam int ST_LSB  = 0;
  localparam int EN_BIT  = 8;
  localparam int CAP_BIT = 12;
  localparam int STS_BIT = 15;

  typedef enum logic [1:0] {
    PWR_D0    = 2'b00,
    PWR_D1    = 2'b01,
    PWR_D2    = 2'b10,
    PWR_D3HOT = 2'b11
  } pwr_state_e;
endpackage

// File: rtl/pmw_state_reg.sv
module pmw_state_reg
  import pmw_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       hard_rst_n,
  input  logic       wr_lo,
  input  logic [1:0] wr_state,
  output pwr_state_e state
);
  pwr_state_e req;
  assign req = pwr_state_e'(wr_state);

  always_ff @(posedge clk) begin
    if (!por_n || !hard_rst_n)
      state <= PWR_D0;
    else if (wr_lo && req != PWR_D2)
      state <= req;
  end

  AST_NO_D2: assert property (@(posedge clk) disable iff (!por_n)
    state != PWR_D2); // R2
  AST_D2_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (hard_rst_n && wr_lo && wr_state == 2'b10) |=> $stable(state)); // R2
endmodule

// File: rtl/pmw_evt_stage.sv
module pmw_evt_stage #(
  parameter int NUM_EVT = 3
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               hard_rst_n,
  input  logic               soft_rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               wake_en,
  output logic               hit
);
  logic [NUM_EVT-1:0] gated;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_gate
    assign gated[g] = evt_in[g] & wake_en;
  end

  always_ff @(posedge clk) begin
    if (!por_n || !hard_rst_n || !soft_rst_n)
      hit <= 1'b0;
    else
      hit <= |gated;
  end

  AST_MASKED_EVT: assert property (@(posedge clk) disable iff (!por_n)
    !wake_en |=> !hit); // R6
endmodule

// File: rtl/pmw_ctx.sv
module pmw_ctx (
  input  logic clk,
  input  logic por_n,
  input  logic hard_rst_n,
  input  logic aux_in,
  input  logic wr_hi,
  input  logic wr_en_val,
  input  logic wr_sts_clr,
  input  logic hit,
  output logic wake_en,
  output logic wake_sts,
  output logic aux_seen
);
  always_ff @(posedge clk) begin
    if (!por_n)
      aux_seen <= aux_in;
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      wake_en  <= 1'b0;
      wake_sts <= 1'b0;
    end else if (!hard_rst_n) begin
      if (!aux_seen) begin
        wake_en  <= 1'b0;
        wake_sts <= 1'b0;
      end
    end else begin
      if (wr_hi)
        wake_en <= wr_en_val;
      if (hit)
        wake_sts <= 1'b1;
      else if (wr_hi && wr_sts_clr)
        wake_sts <= 1'b0;
    end
  end

  AST_AUX_HELD: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> $stable(aux_seen)); // R8
  AST_CTX_KEPT: assert property (@(posedge clk) disable iff (!por_n)
    (!hard_rst_n && aux_seen) |=> ($stable(wake_en) && $stable(wake_sts))); // R9
  AST_CTX_LOST: assert property (@(posedge clk) disable iff (!por_n)
    (!hard_rst_n && !aux_seen) |=> (!wake_en && !wake_sts)); // R9
  AST_W1C: assert property (@(posedge clk) disable iff (!por_n)
    (hard_rst_n && wr_hi && wr_sts_clr && !hit) |=> !wake_sts); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!por_n)
    (hard_rst_n && hit) |=> wake_sts); // R11
endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
  import pmw_pkg::*;
#(
  parameter int NUM_EVT = 3
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        hard_rst_n,
  input  logic        soft_rst_n,
  input  logic        aux_pwr_det,
  input  logic        reg_wr,
  input  logic [1:0]  reg_be,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        evt_link,
  input  logic        evt_magic,
  input  logic        evt_frame,
  output logic        pme_n
);
  pwr_state_e         state;
  logic               wake_en, wake_sts, aux_seen, hit;
  logic               wr_lo, wr_hi;
  logic               pme_n_q;
  logic [NUM_EVT-1:0] evt_vec;

  assign wr_lo   = reg_wr & reg_be[0];
  assign wr_hi   = reg_wr & reg_be[1];
  assign evt_vec = NUM_EVT'({evt_frame, evt_magic, evt_link});

  pmw_state_reg u_state (
    .clk        (clk),
    .por_n      (por_n),
    .hard_rst_n (hard_rst_n),
    .wr_lo      (wr_lo),
    .wr_state   (reg_wdata[ST_LSB+1:ST_LSB]),
    .state      (state)
  );

  pmw_evt_stage #(.NUM_EVT(NUM_EVT)) u_evt (
    .clk        (clk),
    .por_n      (por_n),
    .hard_rst_n (hard_rst_n),
    .soft_rst_n (soft_rst_n),
    .evt_in     (evt_vec),
    .wake_en    (wake_en),
    .hit        (hit)
  );

  pmw_ctx u_ctx (
    .clk        (clk),
    .por_n      (por_n),
    .hard_rst_n (hard_rst_n),
    .aux_in     (aux_pwr_det),
    .wr_hi      (wr_hi),
    .wr_en_val  (reg_wdata[EN_BIT]),
    .wr_sts_clr (reg_wdata[STS_BIT]),
    .hit        (hit),
    .wake_en    (wake_en),
    .wake_sts   (wake_sts),
    .aux_seen   (aux_seen)
  );

  always_ff @(posedge clk) begin
    if (!por_n)
      pme_n_q <= 1'b1;
    else
      pme_n_q <= ~(wake_en & wake_sts);
  end
  assign pme_n = pme_n_q;

  always_comb begin
    reg_rdata = '0;
    reg_rdata[ST_LSB+1:ST_LSB] = state;
    reg_rdata[EN_BIT]  = wake_en;
    reg_rdata[CAP_BIT] = aux_seen;
    reg_rdata[STS_BIT] = wake_sts;
  end

  AST_PME_FOLLOW: assert property (@(posedge clk) disable iff (!por_n)
    (wake_en && wake_sts) |=> !pme_n); // R7
  AST_PME_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    !pme_n |-> $past(wake_en && wake_sts)); // R7
  AST_SOFT_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    (!soft_rst_n && hard_rst_n && !reg_wr && !hit) |=> $stable(reg_rdata)); // R10
endmodule

// File: tb/sim_pm_wake_ctrl.sv
module sim_pm_wake_ctrl;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, hard_rst_n = 1'b1, soft_rst_n = 1'b1;
  logic        aux_pwr_det = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_be = 2'b00;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        evt_link = 1'b0, evt_magic = 1'b0, evt_frame = 1'b0;
  logic        pme_n;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  pm_wake_ctrl u0 (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] be, logic [15:0] d);
    reg_wr = 1'b1; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 2'b00; reg_wdata = '0;
  endtask

  task automatic pulse(int which);
    case (which)
      0: evt_link = 1'b1;
      1: evt_magic = 1'b1;
      default: evt_frame = 1'b1;
    endcase
    @(negedge clk);
    evt_link = 1'b0; evt_magic = 1'b0; evt_frame = 1'b0;
  endtask

  task automatic do_por(logic aux);
    aux_pwr_det = aux; por_n = 1'b0;
    cyc(3);
    por_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset;
    do_por(1'b1);
    check("R1 readback after por", reg_rdata, 16'h1000);
    check("R1 pme_n after por", {15'd0, pme_n}, 16'h0001);
    aux_pwr_det = 1'b0;
    cyc(2);
    check("R8 capability held after aux drops", reg_rdata, 16'h1000);
  endtask

  task automatic t_state;
    wr(2'b01, 16'h0003);
    check("R2 write D3hot", reg_rdata, 16'h1003);
    wr(2'b01, 16'h0002);
    check("R2 D2 request ignored", reg_rdata, 16'h1003);
    wr(2'b01, 16'h0001);
    check("R2 write D1", reg_rdata, 16'h1001);
    wr(2'b01, 16'h0000);
    check("R2 write D0", reg_rdata, 16'h1000);
  endtask

  task automatic t_bytes;
    wr(2'b10, 16'h0103);
    check("R3 upper byte only", reg_rdata, 16'h1100);
    wr(2'b01, 16'h0001);
    check("R3 lower byte only", reg_rdata, 16'h1101);
    wr(2'b00, 16'h0003);
    check("R3 no byte enables", reg_rdata, 16'h1101);
    wr(2'b11, 16'h6EFD);
    check("R4 reserved and capability bits ignored", reg_rdata, 16'h1001);
    wr(2'b01, 16'h0000);
  endtask

  task automatic t_wake;
    wr(2'b10, 16'h0100);
    pulse(0);
    cyc(1);
    check("R6 link event sets status", reg_rdata, 16'h9100);
    cyc(1);
    check("R7 pme_n asserted", {15'd0, pme_n}, 16'h0000);
    cyc(3);
    check("R7 pme_n held low", {15'd0, pme_n}, 16'h0000);
    wr(2'b10, 16'h0000);
    check("R7 clearing enable keeps status", reg_rdata, 16'h9000);
    cyc(1);
    check("R7 pme_n released by enable clear", {15'd0, pme_n}, 16'h0001);
    wr(2'b10, 16'h0100);
    cyc(1);
    check("R7 pme_n reasserted", {15'd0, pme_n}, 16'h0000);
    wr(2'b10, 16'h0100);
    check("R5 writing zero keeps status", reg_rdata, 16'h9100);
    wr(2'b10, 16'h8100);
    check("R5 write one clears status", reg_rdata, 16'h1100);
    cyc(1);
    check("R7 pme_n released by status clear", {15'd0, pme_n}, 16'h0001);
    pulse(1);
    cyc(1);
    check("R6 magic event sets status", reg_rdata, 16'h9100);
    wr(2'b10, 16'h8100);
    pulse(2);
    cyc(1);
    check("R6 frame event sets status", reg_rdata, 16'h9100);
    wr(2'b10, 16'h8000);
    cyc(1);
  endtask

  task automatic t_masked;
    pulse(1);
    cyc(3);
    check("R6 event ignored while disabled", reg_rdata, 16'h1000);
    check("R6 pme_n idle while disabled", {15'd0, pme_n}, 16'h0001);
  endtask

  task automatic t_coincide;
    wr(2'b10, 16'h0100);
    evt_frame = 1'b1;
    @(negedge clk);
    evt_frame = 1'b0;
    wr(2'b10, 16'h8100);
    check("R11 event beats clear", reg_rdata, 16'h9100);
    wr(2'b10, 16'h8000);
    cyc(1);
  endtask

  task automatic t_soft;
    wr(2'b11, 16'h0103);
    pulse(0);
    cyc(2);
    soft_rst_n = 1'b0;
    cyc(3);
    soft_rst_n = 1'b1;
    cyc(1);
    check("R10 soft reset keeps register", reg_rdata, 16'h9103);
    check("R10 soft reset keeps pme_n", {15'd0, pme_n}, 16'h0000);
  endtask

  task automatic t_hard_aux;
    hard_rst_n = 1'b0;
    wr(2'b11, 16'h0001);
    cyc(1);
    hard_rst_n = 1'b1;
    cyc(1);
    check("R9 hard reset keeps context with aux", reg_rdata, 16'h9100);
    check("R9 pme_n kept through hard reset", {15'd0, pme_n}, 16'h0000);
    wr(2'b10, 16'h8000);
    cyc(1);
  endtask

  task automatic t_noaux;
    do_por(1'b0);
    check("R8 capability clear without aux", reg_rdata, 16'h0000);
    aux_pwr_det = 1'b1;
    cyc(1);
    check("R8 late aux ignored", reg_rdata, 16'h0000);
    wr(2'b11, 16'h0103);
    pulse(2);
    cyc(2);
    check("R6 status set before hard reset", reg_rdata, 16'h8103);
    hard_rst_n = 1'b0;
    cyc(2);
    hard_rst_n = 1'b1;
    cyc(1);
    check("R9 hard reset clears context without aux", reg_rdata, 16'h0000);
    check("R9 pme_n released without aux", {15'd0, pme_n}, 16'h0001);
  endtask

  initial begin
    t_reset();
    t_state();
    t_bytes();
    t_wake();
    t_masked();
    t_coincide();
    t_soft();
    t_hard_aux();
    t_noaux();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        cyc(20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule